// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Core

This block is a small 32-bit load/store processor core. Each instruction is fetched, decoded, executed and retired within a single clock. It has a program counter, a 32-entry register file with two read ports and one write port, an ALU, a main decoder and an ALU-function decoder. It supports word load and store, five register-to-register ALU operations, branch-if-equal, an absolute jump, jump-and-link and jump-to-register.

Both memories are outside the core. The instruction port is a combinational read: the core drives a byte address and expects the word back in the same cycle. The data port has separate read and write strobes. The owner of the data memory performs a write at the rising edge when the write strobe is high. The PC and the register file also change only at the rising edge.

Top module: `sc_core`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high at a rising edge, the PC is set to 0 and `imem_addr` reads 0. No data write and no register write happens during reset.
- R2: Instructions are decoded with these fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0]. ALU instructions (opcode 0) write their result to rd. A load writes its result to rt.
- R3: Load is opcode 35 and store is opcode 43. Both use the address rs + sign-extended [15:0]. A load raises `dmem_rd` and writes `dmem_rdata` to rt. A store raises `dmem_wr` and drives rt on `dmem_wdata`. The two strobes are never high together.
- R4: With opcode 0, funct selects the operation: 0x20 is add, 0x22 is rs minus rt, 0x24 is AND, 0x25 is OR and 0x2A is set-less-than. Set-less-than writes 1 when rs < rt as signed values and 0 otherwise.
- R5: Branch-if-equal is opcode 4. When rs equals rt, the next PC is PC+4 + (sign-extended [15:0] << 2); otherwise the next PC is PC+4. Negative offsets work.
- R6: Jump is opcode 2. The next PC is {PC[31:28], [25:0], 2'b00}.
- R7: Jump-and-link is opcode 3. It jumps to the same target as R6 and writes PC+4 into register 31.
- R8: Jump-to-register is opcode 0 with funct 0x08. The next PC is the value of register rs, and no register is written.
- R9: Register 0 always reads as zero, and writes to it are ignored.
- R10: Load, store and ALU instructions advance the PC by exactly 4. `imem_addr` is always word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes at the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched (the PC) |
| imem_data | input | 32 | Instruction word, returned combinationally |
| dmem_addr | output | 32 | Data byte address (ALU result) |
| dmem_wdata | output | 32 | Store data (value of rt) |
| dmem_rdata | input | 32 | Load data, returned combinationally |
| dmem_rd | output | 1 | Data read strobe, high for a load |
| dmem_wr | output | 1 | Data write strobe, high for a store |

## Verification
The bench runs one program for every ordered pair taken from a set of eight operands. The set includes 0, -1, the most positive and most negative values, and equal pairs. Each result is then read back from data memory.

Signed set-less-than is the weakest point: an unsigned compare gives the wrong answer whenever the sign bits differ. The bench also checks:
- The branch is taken only on equal operands; a wrong zero flag leaves a marker word written, or missing, in memory.
- A backward branch offset gives the final PC; a missing sign extension sends the PC far away.
- The link value is the address of the instruction after the call, so an off-by-four return address shows up in two stored words.
- A register-0 write must be dropped.
- A jump must skip its shadow instruction; counting data writes catches an extra or missing store.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

   localparam logic [5:0] OPC_RTYPE = 6'd0;
   localparam logic [5:0] OPC_JMP   = 6'd2;
   localparam logic [5:0] OPC_JAL   = 6'd3;
   localparam logic [5:0] OPC_BEQ   = 6'd4;
   localparam logic [5:0] OPC_LOAD  = 6'd35;
   localparam logic [5:0] OPC_STORE = 6'd43;

   localparam logic [5:0] FN_JR  = 6'h08;
   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [2:0] {
      ALU_AND = 3'b000,
      ALU_OR  = 3'b001,
      ALU_ADD = 3'b010,
      ALU_SUB = 3'b110,
      ALU_SLT = 3'b111
   } alu_fn_e;

   typedef enum logic [1:0] {
      CLS_MEM  = 2'b00,
      CLS_CMP  = 2'b01,
      CLS_REG  = 2'b10,
      CLS_JUMP = 2'b11
   } op_class_e;

   typedef enum logic [1:0] {
      NPC_SEQ    = 2'd0,
      NPC_BRANCH = 2'd1,
      NPC_TARGET = 2'd2,
      NPC_REG    = 2'd3
   } npc_sel_e;

   typedef enum logic [1:0] {
      DST_RT   = 2'd0,
      DST_RD   = 2'd1,
      DST_LINK = 2'd2
   } dst_sel_e;

   typedef enum logic [1:0] {
      WB_ALU  = 2'd0,
      WB_MEM  = 2'd1,
      WB_LINK = 2'd2
   } wb_sel_e;

   typedef struct packed {
      op_class_e op_class;
      logic      use_imm;
      logic      reg_we;
      logic      mem_rd;
      logic      mem_wr;
      logic      is_branch;
      npc_sel_e  npc_sel;
      dst_sel_e  dst_sel;
      wb_sel_e   wb_sel;
   } ctrl_t;

endpackage

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr_a,
   input  logic [AW-1:0]    raddr_b,
   output logic [WIDTH-1:0] rdata_a,
   output logic [WIDTH-1:0] rdata_b
);

   logic [WIDTH-1:0] cells [DEPTH];

   // Entry 0 never stores anything; the others write only when addressed.
   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
      if (gi == 0) begin : g_zero
         assign cells[gi] = '0;
      end else begin : g_store
         always_ff @(posedge clk) begin
            if (we && (waddr == AW'(gi))) cells[gi] <= wdata;
         end
      end
   end

   assign rdata_a = cells[raddr_a];
   assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/sc_alu.sv
module sc_alu import sc_core_pkg::*; #(
   parameter int WIDTH        = 32,
   parameter bit SLT_FROM_SUB = 1'b1
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  alu_fn_e          fn,
   output logic [WIDTH-1:0] res,
   output logic             is_zero
);

   logic [WIDTH-1:0] diff;
   logic             less;

   assign diff = opa - opb;

   if (SLT_FROM_SUB) begin : g_slt_sub
      // Reuse the subtractor: signs differ -> a is less iff a negative.
      assign less = (opa[WIDTH-1] ^ opb[WIDTH-1]) ? opa[WIDTH-1] : diff[WIDTH-1];
   end else begin : g_slt_cmp
      assign less = $signed(opa) < $signed(opb);
   end

   always_comb begin
      unique case (fn)
         ALU_AND: res = opa & opb;
         ALU_OR:  res = opa | opb;
         ALU_ADD: res = opa + opb;
         ALU_SUB: res = diff;
         ALU_SLT: res = {{(WIDTH-1){1'b0}}, less};
         default: res = opa + opb;
      endcase
   end

   assign is_zero = (res == '0);

endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec import sc_core_pkg::*; (
   input  op_class_e  op_class,
   input  logic [5:0] funct,
   output alu_fn_e    fn
);

   always_comb begin
      unique case (op_class)
         CLS_MEM:  fn = ALU_ADD;
         CLS_CMP:  fn = ALU_SUB;
         CLS_JUMP: fn = ALU_ADD;
         CLS_REG: begin
            unique case (funct)
               FN_SUB:  fn = ALU_SUB;
               FN_AND:  fn = ALU_AND;
               FN_OR:   fn = ALU_OR;
               FN_SLT:  fn = ALU_SLT;
               default: fn = ALU_ADD;
            endcase
         end
         default: fn = ALU_ADD;
      endcase
   end

endmodule

// File: rtl/sc_main_dec.sv
module sc_main_dec import sc_core_pkg::*; (
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctrl
);

   always_comb begin
      ctrl           = '0;
      ctrl.op_class  = CLS_MEM;
      ctrl.npc_sel   = NPC_SEQ;
      ctrl.dst_sel   = DST_RT;
      ctrl.wb_sel    = WB_ALU;
      unique case (opcode)
         OPC_RTYPE: begin
            ctrl.op_class = CLS_REG;
            if (funct == FN_JR) begin
               ctrl.op_class = CLS_JUMP;
               ctrl.npc_sel  = NPC_REG;
            end else begin
               ctrl.reg_we  = 1'b1;
               ctrl.dst_sel = DST_RD;
            end
         end
         OPC_LOAD: begin
            ctrl.use_imm = 1'b1;
            ctrl.reg_we  = 1'b1;
            ctrl.mem_rd  = 1'b1;
            ctrl.wb_sel  = WB_MEM;
         end
         OPC_STORE: begin
            ctrl.use_imm = 1'b1;
            ctrl.mem_wr  = 1'b1;
         end
         OPC_BEQ: begin
            ctrl.op_class  = CLS_CMP;
            ctrl.is_branch = 1'b1;
         end
         OPC_JMP: begin
            ctrl.op_class = CLS_JUMP;
            ctrl.npc_sel  = NPC_TARGET;
         end
         OPC_JAL: begin
            ctrl.op_class = CLS_JUMP;
            ctrl.npc_sel  = NPC_TARGET;
            ctrl.reg_we   = 1'b1;
            ctrl.dst_sel  = DST_LINK;
            ctrl.wb_sel   = WB_LINK;
         end
         default: ctrl.op_class = CLS_MEM;
      endcase
   end

endmodule

// File: rtl/sc_core.sv
module sc_core import sc_core_pkg::*; #(
   parameter int          XLEN         = 32,
   parameter int          NREGS        = 32,
   parameter int          LINK_REG     = 31,
   parameter logic [31:0] RESET_PC     = 32'h0,
   parameter bit          SLT_FROM_SUB = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   output logic [31:0] imem_addr,
   input  logic [31:0] imem_data,
   output logic [31:0] dmem_addr,
   output logic [31:0] dmem_wdata,
   input  logic [31:0] dmem_rdata,
   output logic        dmem_rd,
   output logic        dmem_wr
);

   localparam int RAW    = $clog2(NREGS);
   localparam int IMM_W  = 16;
   localparam int TGT_W  = 26;
   localparam int PAGE_W = XLEN - TGT_W - 2;

   // Elaboration-time parameter checks
   if (XLEN != 32) begin : g_bad_xlen
      $error("sc_core: XLEN must be 32 to match the instruction fields");
   end
   if (NREGS < 2 || NREGS > 32 || (1 << RAW) != NREGS) begin : g_bad_nregs
      $error("sc_core: NREGS must be a power of two between 2 and 32");
   end
   if (LINK_REG <= 0 || LINK_REG >= NREGS) begin : g_bad_link
      $error("sc_core: LINK_REG must name a writable register");
   end
   if (RESET_PC[1:0] != 2'b00) begin : g_bad_rst_pc
      $error("sc_core: RESET_PC must be word aligned");
   end

   logic [XLEN-1:0] pc_q, pc_d, pc_inc, br_tgt, jmp_tgt, imm_ext;
   logic [5:0]      opcode, funct;
   logic [RAW-1:0]  rs_a, rt_a, rd_a, wr_a;
   logic [XLEN-1:0] rs_v, rt_v, alu_b, alu_y, wb_v;
   logic            alu_z, take_br, rf_we;
   ctrl_t           ctrl;
   alu_fn_e         alu_fn;
   npc_sel_e        npc_sel;

   // Field extraction
   assign opcode  = imem_data[31:26];
   assign funct   = imem_data[5:0];
   assign rs_a    = imem_data[21 +: RAW];
   assign rt_a    = imem_data[16 +: RAW];
   assign rd_a    = imem_data[11 +: RAW];
   assign imm_ext = {{(XLEN-IMM_W){imem_data[IMM_W-1]}}, imem_data[IMM_W-1:0]};

   sc_main_dec u_main_dec (
      .opcode (opcode),
      .funct  (funct),
      .ctrl   (ctrl)
   );

   sc_alu_dec u_alu_dec (
      .op_class (ctrl.op_class),
      .funct    (funct),
      .fn       (alu_fn)
   );

   sc_regfile #(.WIDTH(XLEN), .DEPTH(NREGS)) u_rf (
      .clk     (clk),
      .we      (rf_we),
      .waddr   (wr_a),
      .wdata   (wb_v),
      .raddr_a (rs_a),
      .raddr_b (rt_a),
      .rdata_a (rs_v),
      .rdata_b (rt_v)
   );

   assign alu_b = ctrl.use_imm ? imm_ext : rt_v;

   sc_alu #(.WIDTH(XLEN), .SLT_FROM_SUB(SLT_FROM_SUB)) u_alu (
      .opa     (rs_v),
      .opb     (alu_b),
      .fn      (alu_fn),
      .res     (alu_y),
      .is_zero (alu_z)
   );

   // Register write-back
   always_comb begin
      unique case (ctrl.dst_sel)
         DST_RD:   wr_a = rd_a;
         DST_LINK: wr_a = RAW'(LINK_REG);
         default:  wr_a = rt_a;
      endcase
      unique case (ctrl.wb_sel)
         WB_MEM:  wb_v = dmem_rdata;
         WB_LINK: wb_v = pc_inc;
         default: wb_v = alu_y;
      endcase
   end

   assign rf_we = ctrl.reg_we & ~rst;

   // Next-PC selection
   assign pc_inc  = pc_q + XLEN'(4);
   assign br_tgt  = pc_inc + {imm_ext[XLEN-3:0], 2'b00};
   assign jmp_tgt = {pc_q[XLEN-1 -: PAGE_W], imem_data[TGT_W-1:0], 2'b00};
   assign take_br = ctrl.is_branch & alu_z;
   assign npc_sel = take_br ? NPC_BRANCH : ctrl.npc_sel;

   always_comb begin
      unique case (npc_sel)
         NPC_BRANCH: pc_d = br_tgt;
         NPC_TARGET: pc_d = jmp_tgt;
         NPC_REG:    pc_d = {rs_v[XLEN-1:2], 2'b00};
         default:    pc_d = pc_inc;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) pc_q <= RESET_PC;
      else     pc_q <= pc_d;
   end

   // Port outputs
   assign imem_addr  = pc_q;
   assign dmem_addr  = alu_y;
   assign dmem_wdata = rt_v;
   assign dmem_rd    = ctrl.mem_rd & ~rst;
   assign dmem_wr    = ctrl.mem_wr & ~rst;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
   input logic        clk,
   input logic        rst,
   input logic [31:0] imem_addr,
   input logic [31:0] imem_data,
   input logic        dmem_rd,
   input logic        dmem_wr
);

   logic [5:0] op;
   logic       seq_kind;
   logic       past_valid;

   assign op       = imem_data[31:26];
   assign seq_kind = (op == 6'd35) || (op == 6'd43) ||
                     ((op == 6'd0) && (imem_data[5:0] != 6'h08));

   always_ff @(posedge clk) past_valid <= 1'b1;

   p_pc_reset_r1: assert property (@(posedge clk)
      past_valid && $past(rst) |-> imem_addr == 32'h0);

   p_no_write_in_reset_r1: assert property (@(posedge clk)
      rst |-> !dmem_wr);

   p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
      !(dmem_rd && dmem_wr));

   p_load_strobe_r3: assert property (@(posedge clk) disable iff (rst)
      (op == 6'd35) |-> dmem_rd);

   p_store_strobe_r3: assert property (@(posedge clk) disable iff (rst)
      (op == 6'd43) |-> dmem_wr);

   p_j_target_r6: assert property (@(posedge clk) disable iff (rst)
      (op == 6'd2) |=> imem_addr == {$past(imem_addr[31:28]), $past(imem_data[25:0]), 2'b00});

   p_jal_target_r7: assert property (@(posedge clk) disable iff (rst)
      (op == 6'd3) |=> imem_addr == {$past(imem_addr[31:28]), $past(imem_data[25:0]), 2'b00});

   p_seq_pc_r10: assert property (@(posedge clk) disable iff (rst)
      seq_kind |=> imem_addr == $past(imem_addr) + 32'd4);

   p_align_r10: assert property (@(posedge clk) disable iff (rst)
      imem_addr[1:0] == 2'b00);

endmodule

bind sc_core sc_core_chk u_sc_core_chk (
   .clk       (clk),
   .rst       (rst),
   .imem_addr (imem_addr),
   .imem_data (imem_data),
   .dmem_rd   (dmem_rd),
   .dmem_wr   (dmem_wr)
);

// File: tb/sc_core_bench.sv
`timescale 1ns/1ps
module sc_core_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_rd, dmem_wr;

   logic [31:0] imem [64];
   logic [31:0] dmem [64];
   int          errors = 0;
   int          checks = 0;
   int          wr_count = 0;

   always #2.5 clk = ~clk;

   sc_core u_sc_core (
      .clk        (clk),
      .rst        (rst),
      .imem_addr  (imem_addr),
      .imem_data  (imem_data),
      .dmem_addr  (dmem_addr),
      .dmem_wdata (dmem_wdata),
      .dmem_rdata (dmem_rdata),
      .dmem_rd    (dmem_rd),
      .dmem_wr    (dmem_wr)
   );

   assign imem_data  = imem[imem_addr[7:2]];
   assign dmem_rdata = dmem[dmem_addr[7:2]];

   always @(posedge clk) begin
      if (dmem_wr) begin
         dmem[dmem_addr[7:2]] <= dmem_wdata;
         wr_count <= wr_count + 1;
      end
   end

   function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
      return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
      return {op, 5'(rs), 5'(rt), 16'(imm)};
   endfunction

   function automatic logic [31:0] enc_j(input logic [5:0] op, input int word);
      return {op, 26'(word)};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load_program();
      for (int i = 0; i < 64; i++) imem[i] = 32'h0;
      imem[0]  = enc_i(6'd35, 0, 1, 0);        // lw  r1, 0(r0)
      imem[1]  = enc_i(6'd35, 0, 2, 4);        // lw  r2, 4(r0)
      imem[2]  = enc_r(1, 2, 3, 6'h20);        // add r3
      imem[3]  = enc_r(1, 2, 4, 6'h22);        // sub r4
      imem[4]  = enc_r(1, 2, 5, 6'h24);        // and r5
      imem[5]  = enc_r(1, 2, 6, 6'h25);        // or  r6
      imem[6]  = enc_r(1, 2, 7, 6'h2A);        // slt r7
      imem[7]  = enc_i(6'd43, 0, 3, 16);
      imem[8]  = enc_i(6'd43, 0, 4, 20);
      imem[9]  = enc_i(6'd43, 0, 5, 24);
      imem[10] = enc_i(6'd43, 0, 6, 28);
      imem[11] = enc_i(6'd43, 0, 7, 32);
      imem[12] = enc_i(6'd35, 0, 9, 8);        // marker into r9
      imem[13] = enc_i(6'd4, 1, 2, 1);         // beq r1,r2 -> 15
      imem[14] = enc_i(6'd43, 0, 9, 36);       // only when not equal
      imem[15] = enc_j(6'd2, 17);              // j 17
      imem[16] = enc_i(6'd43, 0, 9, 52);       // jump shadow, skipped
      imem[17] = enc_j(6'd3, 20);              // jal 20
      imem[18] = enc_i(6'd43, 0, 31, 40);      // after return
      imem[19] = enc_i(6'd4, 0, 0, -1);        // self loop
      imem[20] = enc_i(6'd43, 0, 31, 44);
      imem[21] = enc_r(1, 2, 0, 6'h20);        // write to r0
      imem[22] = enc_i(6'd43, 0, 0, 48);
      imem[23] = enc_r(31, 0, 0, 6'h08);       // jr r31
   endtask

   task automatic run_case(input logic [31:0] a, input logic [31:0] b);
      logic [31:0] exp_slt;
      int          exp_wr;
      @(negedge clk);
      rst = 1'b1;
      for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
      dmem[0] = a;
      dmem[1] = b;
      dmem[2] = 32'h55;
      @(negedge clk);
      @(negedge clk);
      check("R1 pc in reset", imem_addr, 32'h0);
      wr_count = 0;
      rst = 1'b0;
      repeat (40) @(negedge clk);
      exp_slt = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      exp_wr  = (a == b) ? 8 : 9;
      check("R2 R4 add to rd", dmem[4], a + b);
      check("R4 sub", dmem[5], a - b);
      check("R4 and", dmem[6], a & b);
      check("R4 or", dmem[7], a | b);
      check("R4 signed slt", dmem[8], exp_slt);
      check("R5 beq marker", dmem[9], (a == b) ? 32'h0 : 32'h55);
      check("R6 jump shadow skipped", dmem[13], 32'h0);
      check("R7 link at target", dmem[11], 32'd72);
      check("R8 jr returned with link", dmem[10], 32'd72);
      check("R9 r0 write ignored", dmem[12], 32'h0);
      check("R5 R10 backward loop pc", imem_addr, 32'd76);
      check("R3 store count", 32'(wr_count), 32'(exp_wr));
   endtask

   logic [31:0] vals [8];

   initial begin
      vals[0] = 32'h0000_0000;
      vals[1] = 32'h0000_0001;
      vals[2] = 32'hFFFF_FFFF;
      vals[3] = 32'h7FFF_FFFF;
      vals[4] = 32'h8000_0000;
      vals[5] = 32'h0000_0005;
      vals[6] = 32'h1234_ABCD;
      vals[7] = 32'hF0F0_0F0F;
      load_program();
      @(negedge clk);
      check("R1 pc at first reset", imem_addr, 32'h0);
      check("R1 no store in reset", {31'd0, dmem_wr}, 32'h0);
      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 8; j++) begin
            run_case(vals[i], vals[j]);
         end
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1000000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule